// File: doc/BRIEF.md
# Bidirectional Port Byte Queue with Turnaround Interrupt

This block is a byte queue that sits between a parallel port engine and a local processor. A direction setting decides which side fills the queue and which side drains it. In forward direction the port pushes bytes arriving from the host and the processor reads them. In reverse direction the processor writes bytes and the port pops them toward the host.

The host can turn the link back to forward while reverse bytes are still queued. When that happens, the block raises a sticky interrupt. The processor then reads the live occupancy count to learn how many bytes were not sent and adjusts its own buffer pointers. It then flushes the queue and switches the direction to forward so that host data can be accepted again. The processor bus decode and the port handshake protocol live outside this block.

Top module: `bidir_byte_fifo`

## Requirements
- R1: After reset, count_o is 0, empty_o is 1, full_o is 0, irq_o is 0 and dir_o is 0 (forward).
- R2: A cycle with cpu_dir_set_i high loads cpu_dir_i into the direction register (0 forward, 1 reverse). dir_o shows the new value after that clock edge.
- R3: In forward direction, port_push_i stores port_wdata_i and cpu_rd_i removes the oldest byte. cpu_rdata_o always shows the oldest byte, so bytes leave in the order they arrived.
- R4: In reverse direction, cpu_wr_i stores cpu_wdata_i and port_pop_i removes the oldest byte. port_rdata_o shows the oldest byte, in arrival order.
- R5: Writes from the side that is not the filler are ignored. In reverse, port_push_i has no effect and port_stall_o is 1. In forward, cpu_wr_i has no effect.
- R6: The queue holds DEPTH bytes (16 by default). full_o is 1 at that fill level, and a push without a same-cycle pop while full is dropped.
- R7: A pop while empty is dropped, and count_o stays 0.
- R8: A push and a pop accepted in the same cycle leave count_o unchanged.
- R9: count_o reports the live number of stored bytes after every accepted push or pop.
- R10: cpu_flush_i empties the queue: count_o is 0 and empty_o is 1 after that clock edge. Flush takes priority over a same-cycle push or pop.
- R11: If host_rev_i falls from 1 to 0 while the direction is reverse and the queue is not empty, irq_o goes to 1 after the clock edge that samples the 0. If the queue is empty, the same turnaround raises no interrupt.
- R12: irq_o stays 1 until a cycle with cpu_irq_clr_i high. It is 0 after that edge unless a new turnaround happens in the same cycle, in which case the set wins.
- R13: After the interrupt, count_o keeps the number of unsent bytes until a pop or a flush changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | Processor write strobe (used in reverse direction) |
| cpu_wdata_i | input | DATA_W | Processor write byte |
| cpu_rd_i | input | 1 | Processor read/pop strobe (used in forward direction) |
| cpu_rdata_o | output | DATA_W | Oldest queued byte, processor side |
| cpu_flush_i | input | 1 | Empty the queue |
| cpu_dir_set_i | input | 1 | Load the direction register |
| cpu_dir_i | input | 1 | Direction value to load: 0 forward, 1 reverse |
| cpu_irq_clr_i | input | 1 | Clear the turnaround interrupt |
| irq_o | output | 1 | Sticky turnaround interrupt |
| count_o | output | $clog2(DEPTH+1) | Live fill count |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| dir_o | output | 1 | Current direction: 0 forward, 1 reverse |
| port_push_i | input | 1 | Port push strobe (used in forward direction) |
| port_wdata_i | input | DATA_W | Port push byte |
| port_pop_i | input | 1 | Port pop strobe (used in reverse direction) |
| port_rdata_o | output | DATA_W | Oldest queued byte, port side |
| port_stall_o | output | 1 | Port may not push (reverse direction or full) |
| host_rev_i | input | 1 | Host link direction: 1 reverse, 0 forward |

## Verification
The hardest case to reach is a turnaround that strands data. The bench must first switch to reverse and have the host side hold host_rev_i high. The processor then queues several bytes, and the port drains only part of them before host_rev_i drops. The stimulus then checks that the stranded count is held while the interrupt stays set. It also checks that a flush followed by a switch to forward lets host pushes land again, and that a turnaround with an empty queue stays silent.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;
endpackage

// File: rtl/bdf_dir_ctrl.sv
module bdf_dir_ctrl
  import bdf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_set_i,
  input  logic              dir_val_i,
  input  logic              full_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_rd_i,
  input  logic              port_push_i,
  input  logic [DATA_W-1:0] port_wdata_i,
  input  logic              port_pop_i,
  output dir_e              dir_o,
  output logic              push_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              pop_o,
  output logic              port_stall_o
);
  dir_e dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dir_q <= DIR_FWD;
    else if (dir_set_i) dir_q <= dir_e'(dir_val_i);
  end

  // filler and drainer swap with direction
  always_comb begin
    if (dir_q == DIR_REV) begin
      push_o  = cpu_wr_i;
      wdata_o = cpu_wdata_i;
      pop_o   = port_pop_i;
    end else begin
      push_o  = port_push_i;
      wdata_o = port_wdata_i;
      pop_o   = cpu_rd_i;
    end
  end

  assign port_stall_o = (dir_q == DIR_REV) || full_i;
  assign dir_o        = dir_q;
endmodule

// File: rtl/bdf_store.sv
module bdf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;
  logic              push_acc, pop_acc;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o   = (count_q == CW'(DEPTH));
  assign empty_o  = (count_q == '0);
  assign pop_acc  = pop_i && !empty_o && !flush_i;
  // a push into a full queue lands only when a pop frees a slot
  assign push_acc = push_i && (!full_o || pop_acc) && !flush_i;

  always_ff @(posedge clk_i) begin
    if (push_acc) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_acc) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_acc)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_acc, pop_acc})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/bdf_turn_detect.sv
module bdf_turn_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_rev_i,
  input  logic dir_rev_i,
  input  logic occupied_i,
  input  logic clr_i,
  output logic irq_o
);
  logic host_rev_q, irq_q, turn_set;

  assign turn_set = host_rev_q && !host_rev_i && dir_rev_i && occupied_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rev_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      host_rev_q <= host_rev_i;
      irq_q      <= turn_set || (irq_q && !clr_i);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/bidir_byte_fifo.sv
module bidir_byte_fifo
  import bdf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_rd_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              cpu_flush_i,
  input  logic              cpu_dir_set_i,
  input  logic              cpu_dir_i,
  input  logic              cpu_irq_clr_i,
  output logic              irq_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              dir_o,
  input  logic              port_push_i,
  input  logic [DATA_W-1:0] port_wdata_i,
  input  logic              port_pop_i,
  output logic [DATA_W-1:0] port_rdata_o,
  output logic              port_stall_o,
  input  logic              host_rev_i
);
  dir_e              dir;
  logic              push, pop, full, empty;
  logic [DATA_W-1:0] wdata, rdata;
  logic [CW-1:0]     count;

  bdf_dir_ctrl #(.DATA_W(DATA_W)) u_dir (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dir_set_i    (cpu_dir_set_i),
    .dir_val_i    (cpu_dir_i),
    .full_i       (full),
    .cpu_wr_i     (cpu_wr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_rd_i     (cpu_rd_i),
    .port_push_i  (port_push_i),
    .port_wdata_i (port_wdata_i),
    .port_pop_i   (port_pop_i),
    .dir_o        (dir),
    .push_o       (push),
    .wdata_o      (wdata),
    .pop_o        (pop),
    .port_stall_o (port_stall_o)
  );

  bdf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (cpu_flush_i),
    .push_i  (push),
    .wdata_i (wdata),
    .pop_i   (pop),
    .rdata_o (rdata),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  bdf_turn_detect u_turn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_rev_i (host_rev_i),
    .dir_rev_i  (dir == DIR_REV),
    .occupied_i (!empty),
    .clr_i      (cpu_irq_clr_i),
    .irq_o      (irq_o)
  );

  assign cpu_rdata_o  = rdata;
  assign port_rdata_o = rdata;
  assign count_o      = count;
  assign full_o       = full;
  assign empty_o      = empty;
  assign dir_o        = dir;
endmodule

// File: rtl/bdf_checker.sv
module bdf_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_wr_i,
  input logic          cpu_flush_i,
  input logic          cpu_dir_set_i,
  input logic          cpu_irq_clr_i,
  input logic          irq_o,
  input logic [CW-1:0] count_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          dir_o,
  input logic          port_push_i,
  input logic          port_pop_i,
  input logic          port_stall_o,
  input logic          cpu_rd_i
);
  assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  assert_full_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (count_o == CW'(DEPTH)) && !empty_o);

  assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_flush_i |=> (count_o == '0) && empty_o);

  assert_rev_stalls_port_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_o |-> port_stall_o);

  assert_fwd_cpu_wr_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_o && !port_push_i && !cpu_flush_i && !cpu_dir_set_i) |=> count_o <= $past(count_o));

  assert_empty_pop_dropped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !cpu_wr_i && !port_push_i && !cpu_dir_set_i) |=> count_o == '0);

  assert_irq_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !cpu_irq_clr_i) |=> irq_o);

  assert_irq_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(dir_o) && !$past(empty_o));

  assert_count_held_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && dir_o && !port_pop_i && !cpu_wr_i && !cpu_flush_i && !cpu_dir_set_i && !cpu_rd_i)
      |=> $stable(count_o));
endmodule

bind bidir_byte_fifo bdf_checker #(.DEPTH(DEPTH), .CW(CW)) u_bdf_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_wr_i      (cpu_wr_i),
  .cpu_flush_i   (cpu_flush_i),
  .cpu_dir_set_i (cpu_dir_set_i),
  .cpu_irq_clr_i (cpu_irq_clr_i),
  .irq_o         (irq_o),
  .count_o       (count_o),
  .full_o        (full_o),
  .empty_o       (empty_o),
  .dir_o         (dir_o),
  .port_push_i   (port_push_i),
  .port_pop_i    (port_pop_i),
  .port_stall_o  (port_stall_o),
  .cpu_rd_i      (cpu_rd_i)
);

// File: tb/sim_bidir_byte_fifo.sv
module sim_bidir_byte_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 0, cpu_rd = 0, cpu_flush = 0, cpu_dir_set = 0, cpu_dir = 0, cpu_irq_clr = 0;
  logic port_push = 0, port_pop = 0, host_rev = 0;
  logic [DW-1:0] cpu_wdata = '0, port_wdata = '0;
  logic [DW-1:0] cpu_rdata, port_rdata;
  logic irq, full, empty, dir, port_stall;
  logic [CW-1:0] count;

  int errors = 0, checks = 0;
  logic [DW-1:0] exp_q[$];
  logic tb_rev = 0;

  always #4 clk = ~clk;

  bidir_byte_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_rd_i(cpu_rd), .cpu_rdata_o(cpu_rdata),
    .cpu_flush_i(cpu_flush), .cpu_dir_set_i(cpu_dir_set), .cpu_dir_i(cpu_dir),
    .cpu_irq_clr_i(cpu_irq_clr), .irq_o(irq), .count_o(count), .full_o(full),
    .empty_o(empty), .dir_o(dir), .port_push_i(port_push), .port_wdata_i(port_wdata),
    .port_pop_i(port_pop), .port_rdata_o(port_rdata), .port_stall_o(port_stall),
    .host_rev_i(host_rev)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares the head byte on every accepted pop
  always @(negedge clk) begin
    if (rst_n && ((tb_rev && port_pop) || (!tb_rev && cpu_rd)) && exp_q.size() > 0) begin
      logic [DW-1:0] got, want;
      got  = tb_rev ? port_rdata : cpu_rdata;
      want = exp_q.pop_front();
      chk(got == want, tb_rev ? "R4 reverse order" : "R3 forward order", got, want);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic clear_strobes();
    cpu_wr = 0; cpu_rd = 0; cpu_flush = 0; cpu_dir_set = 0; cpu_irq_clr = 0;
    port_push = 0; port_pop = 0;
  endtask

  task automatic port_put(input logic [DW-1:0] b, input bit expect_ok);
    port_push = 1; port_wdata = b;
    if (expect_ok) exp_q.push_back(b);
    step(); clear_strobes();
  endtask

  task automatic cpu_put(input logic [DW-1:0] b, input bit expect_ok);
    cpu_wr = 1; cpu_wdata = b;
    if (expect_ok) exp_q.push_back(b);
    step(); clear_strobes();
  endtask

  task automatic cpu_get();  cpu_rd = 1;  step(); clear_strobes(); endtask
  task automatic port_get(); port_pop = 1; step(); clear_strobes(); endtask

  task automatic set_dir(input bit rev);
    cpu_dir_set = 1; cpu_dir = rev; step(); clear_strobes(); tb_rev = rev;
  endtask

  task automatic flush();
    cpu_flush = 1; step(); clear_strobes(); exp_q.delete();
  endtask

  initial begin
    #1000;
    while (checks < 0) #1;
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(count == 0 && empty && !full && !irq && !dir, "R1 reset state", count, 0);
    rst_n = 1;
    step();
    chk(count == 0 && empty && !irq && dir == 0 && !port_stall, "R1 after release", count, 0);

    // forward flow
    for (int i = 0; i < 5; i++) port_put(8'h10 + 8'(i), 1);
    chk(count == 5, "R9 count after five pushes", count, 5);
    cpu_put(8'hEE, 0);
    chk(count == 5, "R5 cpu write ignored in forward", count, 5);
    for (int i = 0; i < 5; i++) cpu_get();
    chk(count == 0 && empty, "R3 drained", count, 0);
    cpu_get();
    chk(count == 0 && empty, "R7 pop when empty dropped", count, 0);

    // fill to depth
    for (int i = 0; i < DEPTH; i++) port_put(8'hA0 + 8'(i), 1);
    chk(full && count == CW'(DEPTH), "R6 full at depth", count, DEPTH);
    chk(port_stall == 1, "R6 stall when full", port_stall, 1);
    port_put(8'h55, 0);
    chk(count == CW'(DEPTH) && full, "R6 push when full dropped", count, DEPTH);
    // simultaneous push/pop at full
    port_push = 1; port_wdata = 8'h77; cpu_rd = 1; exp_q.push_back(8'h77);
    step(); clear_strobes();
    chk(count == CW'(DEPTH), "R8 push+pop at full", count, DEPTH);
    for (int i = 0; i < DEPTH; i++) cpu_get();
    chk(empty, "R3 full drain order", count, 0);

    // simultaneous push/pop mid level
    for (int i = 0; i < 3; i++) port_put(8'h30 + 8'(i), 1);
    port_push = 1; port_wdata = 8'h3F; cpu_rd = 1; exp_q.push_back(8'h3F);
    step(); clear_strobes();
    chk(count == 3, "R8 push+pop mid", count, 3);

    // flush with a same-cycle push
    cpu_flush = 1; port_push = 1; port_wdata = 8'h99;
    step(); clear_strobes(); exp_q.delete();
    chk(count == 0 && empty, "R10 flush priority", count, 0);

    // reverse direction
    set_dir(1);
    chk(dir == 1 && port_stall == 1, "R2 dir reverse", dir, 1);
    port_put(8'h66, 0);
    chk(count == 0, "R5 port push ignored in reverse", count, 0);
    host_rev = 1;
    for (int i = 0; i < 4; i++) cpu_put(8'hC0 + 8'(i), 1);
    chk(count == 4, "R4 reverse fill", count, 4);
    port_get();
    chk(count == 3 && !irq, "R4 reverse pop", count, 3);

    // host turnaround with data left
    host_rev = 0; step();
    chk(irq == 1, "R11 irq on turnaround", irq, 1);
    chk(count == 3, "R13 count held", count, 3);
    repeat (4) step();
    chk(irq == 1 && count == 3, "R12 irq sticky", irq, 1);
    chk(count == 3, "R13 count still held", count, 3);
    cpu_irq_clr = 1; step(); clear_strobes();
    chk(irq == 0, "R12 irq cleared", irq, 0);

    // recover: flush, forward, accept host data
    flush();
    chk(count == 0, "R10 flush after turnaround", count, 0);
    set_dir(0);
    chk(dir == 0 && !port_stall, "R2 dir forward", dir, 0);
    port_put(8'h5A, 1);
    chk(count == 1, "R3 host push accepted after recovery", count, 1);
    cpu_get();

    // turnaround with empty queue
    set_dir(1);
    host_rev = 1; step();
    host_rev = 0; step(); step();
    chk(irq == 0, "R11 no irq when empty", irq, 0);

    // set wins over clear
    host_rev = 1; cpu_put(8'hD1, 1); step();
    host_rev = 0; cpu_irq_clr = 1; step(); clear_strobes();
    chk(irq == 1, "R12 set beats clear", irq, 1);
    port_get();
    chk(count == 0, "R4 last reverse byte", count, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule